// File: doc/BRIEF.md
# PWM-Synchronised Falling Ramp Generator

This block makes a falling digital reference for a comparator DAC that restarts once per PWM period. Each PWM channel feeding it supplies its time-base counter, its period value and a bit that picks which counter event makes a ramp sync: the counter hitting zero or the counter hitting the period. The block builds its own sync level from those inputs. This sync is separate from any sync chain used to phase-lock PWM time bases, and it works for up, down and up-down counting because it only compares values.

A control field picks which channel restarts the ramp. The chosen sync level goes through a two-flop synchroniser and a rising-edge detector. On each detected edge the ramp loads the start value held in a shadow register, and the active step size is taken from its own shadow register at the same moment. After that the ramp falls by the step on every clock and stops at zero. A second control bit chooses whether the DAC code comes from the upper ten bits of the ramp or from a fixed register value. Software writes all values through a small write-only register port.

Top module: `pwm_ramp_gen`

## Requirements
- R1: During and right after reset, `ramp_out` is 0, `dac_code` is 0, both shadow values are 0, the static code is 0, and the control field selects the static code and channel index 0.
- R2: For each channel, `sync_on_zero` = 1 makes the sync level true while that channel's counter equals 0. `sync_on_zero` = 0 makes it true while the counter equals that channel's period. The other event does not restart the ramp.
- R3: A rising edge of the selected sync level, held steady across a clock edge, reloads the ramp on the third rising clock edge after the level changes. A level that stays high for many clocks gives exactly one reload.
- R4: On every clock edge without a reload, `ramp_out` falls by the active step value.
- R5: When the active step is greater than or equal to `ramp_out`, the next value is 0. The ramp never wraps.
- R6: Address 0 writes the start-value shadow and address 1 writes the step shadow, both 16 bits. Both shadows are copied into the active ramp only on a reload edge, so a write made mid-ramp changes nothing until the next reload.
- R7: Address 2 writes the static DAC code from `reg_wdata[9:0]`. When control bit 0 is 0, `dac_code` is the static code. When it is 1, `dac_code` is `ramp_out[15:6]`.
- R8: Address 3 writes the control field. Bit 0 is the DAC source. The bits from 1 up hold the restart channel index, where 0 selects the first channel (bits [CNT_W-1:0] of the counter buses). Sync events on channels that are not selected do not restart the ramp.
- R9: Register writes take effect on the clock edge where `reg_we` is sampled high. The control field and the static code affect the outputs straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 start, 1 step, 2 static code, 3 control |
| reg_wdata | input | 16 | Register write data |
| tb_cnt | input | NUM_PWM*CNT_W | Time-base counters, channel 0 in the low bits |
| tb_prd | input | NUM_PWM*CNT_W | Period values, channel 0 in the low bits |
| sync_on_zero | input | NUM_PWM | Per-channel sync event select: 1 zero match, 0 period match |
| ramp_out | output | 16 | Current ramp value |
| dac_code | output | 10 | Code driven to the comparator DAC |

## Verification
A reload shows on `ramp_out` three clock edges after the selected sync level rises: two edges in the synchroniser and one in the ramp register. Each later step shows one edge after the one before. Register writes show up at the edge that samples them. `dac_code` follows `ramp_out` and the control bit combinationally, in the same cycle. The bench drives every input at the falling clock edge and updates its reference model at the rising edge from those settled inputs. It compares both outputs at the next falling edge, and the directed checks count the edges between a stimulus and the expected value in the same way.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
    localparam int RAMP_W = 16;
    localparam int DAC_W  = 10;
    localparam int REG_AW = 2;

    typedef logic [RAMP_W-1:0] ramp_t;

    typedef enum logic [REG_AW-1:0] {
        REG_START  = 2'd0,
        REG_STEP   = 2'd1,
        REG_STATIC = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        ramp_t start_val;
        ramp_t step_val;
    } ramp_cfg_t;

    function automatic ramp_t sat_sub(ramp_t a, ramp_t b);
        return (a > b) ? ramp_t'(a - b) : '0;
    endfunction

    function automatic logic [DAC_W-1:0] dac_slice(ramp_t r);
        return r[RAMP_W-1 -: DAC_W];
    endfunction
endpackage

// File: rtl/ramp_sync_source.sv
module ramp_sync_source #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] prd,
    input  logic             on_zero,
    output logic             level
);
    always_comb begin
        if (on_zero) level = (cnt == '0);
        else         level = (cnt == prd);
    end
endmodule

// File: rtl/ramp_sync_detect.sv
module ramp_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic edge_out
);
    logic [2:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[1:0], level_in};
    end

    assign edge_out = stage[1] & ~stage[2];
endmodule

// File: rtl/ramp_regs.sv
module ramp_regs
    import ramp_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  ramp_t             wdata,
    output ramp_cfg_t         shadow,
    output logic [DAC_W-1:0]  static_code,
    output logic              dac_from_ramp,
    output logic [SEL_W-1:0]  src_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow        <= '0;
            static_code   <= '0;
            dac_from_ramp <= 1'b0;
            src_sel       <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                REG_START:  shadow.start_val <= wdata;
                REG_STEP:   shadow.step_val  <= wdata;
                REG_STATIC: static_code      <= wdata[DAC_W-1:0];
                REG_CTRL: begin
                    dac_from_ramp <= wdata[0];
                    src_sel       <= wdata[SEL_W:1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ramp_core.sv
module ramp_core
    import ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      reload,
    input  ramp_cfg_t shadow,
    output ramp_t     ramp,
    output ramp_t     act_step
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ramp     <= '0;
            act_step <= '0;
        end else if (reload) begin
            ramp     <= shadow.start_val;
            act_step <= shadow.step_val;
        end else begin
            ramp     <= sat_sub(ramp, act_step);
        end
    end
endmodule

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen
    import ramp_pkg::*;
#(
    parameter int NUM_PWM = 2,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [1:0]               reg_addr,
    input  logic [15:0]              reg_wdata,
    input  logic [NUM_PWM*CNT_W-1:0] tb_cnt,
    input  logic [NUM_PWM*CNT_W-1:0] tb_prd,
    input  logic [NUM_PWM-1:0]       sync_on_zero,
    output logic [15:0]              ramp_out,
    output logic [9:0]               dac_code
);
    localparam int SEL_W = (NUM_PWM > 1) ? $clog2(NUM_PWM) : 1;
    localparam int SLOTS = 1 << SEL_W;

    ramp_cfg_t          shadow_cfg;
    logic [DAC_W-1:0]   static_code;
    logic               dac_from_ramp;
    logic [SEL_W-1:0]   src_sel;
    logic [SLOTS-1:0]   chan_level;
    logic               sel_level;
    logic               sync_edge;
    ramp_t              act_step;
    ramp_t              ramp_q;

    ramp_regs #(.SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .shadow(shadow_cfg), .static_code(static_code),
        .dac_from_ramp(dac_from_ramp), .src_sel(src_sel)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_src
        if (i < NUM_PWM) begin : g_live
            ramp_sync_source #(.CNT_W(CNT_W)) u_src (
                .cnt(tb_cnt[i*CNT_W +: CNT_W]),
                .prd(tb_prd[i*CNT_W +: CNT_W]),
                .on_zero(sync_on_zero[i]),
                .level(chan_level[i])
            );
        end else begin : g_pad
            assign chan_level[i] = 1'b0;
        end
    end

    assign sel_level = chan_level[src_sel];

    ramp_sync_detect u_det (
        .clk(clk), .rst(rst), .level_in(sel_level), .edge_out(sync_edge)
    );

    ramp_core u_core (
        .clk(clk), .rst(rst), .reload(sync_edge), .shadow(shadow_cfg),
        .ramp(ramp_q), .act_step(act_step)
    );

    assign ramp_out = ramp_q;
    assign dac_code = dac_from_ramp ? dac_slice(ramp_q) : static_code;
endmodule

// File: rtl/ramp_chk.sv
module ramp_chk
    import ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_edge,
    input  ramp_t     ramp_out,
    input  ramp_t     act_step,
    input  ramp_cfg_t shadow_cfg
);
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (rst)
        sync_edge |=> ramp_out == $past(shadow_cfg.start_val));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        sync_edge |=> !sync_edge);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!sync_edge && ramp_out > act_step) |=> ramp_out == ramp_t'($past(ramp_out) - $past(act_step)));

    assert_floor_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!sync_edge && ramp_out <= act_step) |=> ramp_out == '0);

    assert_step_held_R6: assert property (@(posedge clk) disable iff (rst)
        !sync_edge |=> $stable(act_step));

    assert_step_loaded_R6: assert property (@(posedge clk) disable iff (rst)
        sync_edge |=> act_step == $past(shadow_cfg.step_val));
endmodule

bind pwm_ramp_gen ramp_chk u_chk (
    .clk(clk), .rst(rst), .sync_edge(sync_edge), .ramp_out(ramp_out),
    .act_step(act_step), .shadow_cfg(shadow_cfg)
);

// File: tb/sim_pwm_ramp_gen.sv
`timescale 1ns/1ps
module sim_pwm_ramp_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] cnt0 = 16'd5, cnt1 = 16'd3, prd0 = 16'd10, prd1 = 16'd20;
    logic [1:0]  sync_on_zero = 2'b00;
    logic [15:0] ramp_out;
    logic [9:0]  dac_code;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_ramp_gen u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tb_cnt({cnt1, cnt0}), .tb_prd({prd1, prd0}), .sync_on_zero(sync_on_zero),
        .ramp_out(ramp_out), .dac_code(dac_code)
    );

    // Behavioural reference model
    int m_ramp, m_step, m_start_sh, m_step_sh, m_static, m_dac_ramp, m_src;
    int h1, h2, h3;

    function automatic int model_level();
        int c, p, z;
        c = (m_src == 1) ? int'(cnt1) : int'(cnt0);
        p = (m_src == 1) ? int'(prd1) : int'(prd0);
        z = int'(sync_on_zero[m_src]);
        return (z != 0) ? int'(c == 0) : int'(c == p);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ramp = 0; m_step = 0; m_start_sh = 0; m_step_sh = 0;
            m_static = 0; m_dac_ramp = 0; m_src = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            int lvl;
            lvl = model_level();
            if (h2 == 1 && h3 == 0) begin
                m_ramp = m_start_sh;
                m_step = m_step_sh;
            end else begin
                m_ramp = (m_ramp > m_step) ? m_ramp - m_step : 0;
            end
            h3 = h2; h2 = h1; h1 = lvl;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_start_sh = int'(reg_wdata);
                    2'd1: m_step_sh  = int'(reg_wdata);
                    2'd2: m_static   = int'(reg_wdata[9:0]);
                    default: begin
                        m_dac_ramp = int'(reg_wdata[0]);
                        m_src      = int'(reg_wdata[1]);
                    end
                endcase
            end
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 ramp model", int'(ramp_out), m_ramp);
            check("R7 dac model", int'(dac_code),
                  (m_dac_ramp != 0) ? (m_ramp >> 6) : m_static);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        int dir1;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 ramp after reset", int'(ramp_out), 0);
        check("R1 dac after reset", int'(dac_code), 0);

        // R3/R4/R5/R6 on channel 0, period match
        wr(2'd3, 16'h0001);
        wr(2'd0, 16'd1000);
        wr(2'd1, 16'd300);
        cnt0 = 16'd10;
        step(3);
        check("R3 reload third edge", int'(ramp_out), 1000);
        check("R7 dac from ramp", int'(dac_code), 1000 >> 6);
        wr(2'd1, 16'd50);
        check("R4 first step", int'(ramp_out), 700);
        step(1);
        check("R6 old step kept", int'(ramp_out), 400);
        step(1);
        check("R4 third step", int'(ramp_out), 100);
        step(1);
        check("R5 floor", int'(ramp_out), 0);
        step(1);
        check("R3 held level single reload", int'(ramp_out), 0);
        cnt0 = 16'd5;
        step(2);
        cnt0 = 16'd10;
        step(3);
        check("R3 second reload", int'(ramp_out), 1000);
        step(1);
        check("R6 new step after reload", int'(ramp_out), 950);

        // R2 zero-match select
        cnt0 = 16'd5; sync_on_zero[0] = 1'b1;
        step(2);
        cnt0 = 16'd0;
        step(3);
        check("R2 zero match reload", int'(ramp_out), 1000);
        cnt0 = 16'd5;
        step(2);
        cnt0 = 16'd10;
        step(4);
        check("R2 period ignored when zero selected", int'(ramp_out), 700);

        // R8 channel select
        wr(2'd3, 16'h0003);
        cnt0 = 16'd0;
        step(4);
        check("R8 unselected channel ignored", int'(ramp_out), 450);
        cnt0 = 16'd5;
        cnt1 = 16'd20;
        step(3);
        check("R8 channel 1 reload", int'(ramp_out), 1000);

        // R7 / R9 DAC source
        wr(2'd2, 16'hF2A5);
        wr(2'd3, 16'h0002);
        check("R7 static code", int'(dac_code), 16'h2A5);
        check("R9 ramp still running", int'(ramp_out), 900);
        wr(2'd3, 16'h0003);
        check("R7 ramp code", int'(dac_code), 850 >> 6);
        cnt1 = 16'd3;

        // Free-running counters, pseudo-random register traffic
        prd0 = 16'd30; prd1 = 16'd40; cnt0 = 16'd0; cnt1 = 16'd0; dir1 = 1;
        lcg = 32'h1234_5678;
        for (int i = 0; i < 6000; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (i % 2 == 1) begin
                cnt0 = (cnt0 >= prd0) ? 16'd0 : cnt0 + 16'd1;
                if (dir1 == 1 && cnt1 >= prd1) dir1 = -1;
                else if (dir1 == -1 && cnt1 == 0) dir1 = 1;
                cnt1 = (dir1 == 1) ? cnt1 + 16'd1 : cnt1 - 16'd1;
            end
            if (i % 500 == 499) sync_on_zero = lcg[9:8];
            if (i % 23 == 0) begin
                reg_we = 1'b1;
                reg_addr = lcg[17:16];
                reg_wdata = (lcg[17:16] == 2'd1) ? {7'd0, lcg[28:20]} : lcg[31:16];
            end else begin
                reg_we = 1'b0;
            end
            step(1);
        end
        reg_we = 1'b0;
        step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule